// File: doc/BRIEF.md
# Audio Transmit FIFO Register Unit

This block sits between a processor's register bus and an audio serializer. Software configures the transmit path through a configuration register and streams 32-bit sample words into a deep FIFO through a data port. The serializer drains the FIFO through a show-ahead read port. The configuration fields are driven straight out of the block as individual outputs.

The block watches FIFO occupancy and records two conditions in a sticky status register. The first is an empty FIFO (underrun). The second is an occupancy below a programmable threshold, which equals the FIFO depth shifted right by a 4-bit code. Software clears status bits by writing ones to them. A single interrupt line combines a global enable, a per-condition mask and the status bits. The FIFO depth and the version constant are parameters.

Top module: `pcm_fifo_regs`

## Requirements
- R1: The bus takes byte addresses. An access whose two low address bits are not zero is ignored. A read returns its data on `bus_rdata` one cycle after `bus_rd`, and `bus_rdata` holds its value between reads. Word 0x00 reads the nonzero constant VERSION, and writes to it have no effect.
- R2: Offset 0x04 is the configuration register. Bit 0 is transmit enable, bit 1 is interrupt enable, bit 2 is the left-justify flag, bits 15:8 are the clock ratio, bits 21:16 are the sample resolution, bits 27:24 are the level code and bits 31:28 are the channel selection. All other bits read 0. Each field drives its output directly.
- R3: Each write to offset 0x10 pushes one word. `fifo_data` shows the oldest word, and `fifo_pop` removes it, in first-in first-out order. Writes to 0x14, 0x18 and 0x1C have no effect.
- R4: A push while the FIFO holds DEPTH words is dropped and leaves the stored words unchanged. A pop and a push in the same cycle at full remove one word and drop the push.
- R5: Status bit 0 (underrun) at offset 0x0C becomes 1 after any cycle in which the FIFO is empty.
- R6: Status bit 1 (level) becomes 1 after any cycle in which occupancy is below DEPTH >> level code. Code 0 gives DEPTH, and each higher code halves the threshold.
- R7: Writing 1 to a status bit clears it in that cycle. If its condition still holds, the bit sets again on the following cycle.
- R8: `irq` is 1 exactly when configuration bit 1 is set and some status bit is set whose mask bit (offset 0x08, bits 1:0) is also set.
- R9: Reset clears the configuration, the mask, the status, the read data register and the FIFO.
- R10: Reads of offsets 0x10 to 0x1C return 0.
- R11: A pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| fifo_pop | input | 1 | Serializer removes the oldest word |
| fifo_data | output | 32 | Oldest stored word |
| fifo_empty | output | 1 | FIFO holds no words |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_irq_en | output | 1 | Global interrupt enable |
| cfg_left_just | output | 1 | Left-justify flag |
| cfg_clk_ratio | output | 8 | Clock ratio field |
| cfg_sample_bits | output | 6 | Sample resolution field |
| cfg_level_code | output | 4 | Threshold shift code |
| cfg_chan_sel | output | 4 | Channel selection field |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes and the address are known and stable across each clock edge once reset is released. They also assume that a status-clear write and the condition it races with are the only sources of status change. The stimulus issues at most one bus operation per cycle, changes every input on the falling edge, and keeps the strobes low whenever no operation is meant. Corner cases such as a push at full, a pop and a push together at full, a pop when empty, and misaligned accesses are each driven on purpose as single isolated operations.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
   // word indices (byte offset / 4)
   localparam int W_VERSION = 0;
   localparam int W_CONFIG  = 1;
   localparam int W_MASK    = 2;
   localparam int W_STATUS  = 3;
   localparam int W_DATA0   = 4;

   // implemented configuration bits
   localparam logic [31:0] CFG_KEEP = 32'hFF3F_FF07;

   // status bit positions
   localparam int ST_UNDER = 0;
   localparam int ST_LEVEL = 1;
endpackage

// File: rtl/pcm_fifo_store.sv
module pcm_fifo_store #(
   parameter int DEPTH = 2048,
   parameter int DW    = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] occ
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign push_ok = push && (occ != CW'(DEPTH));
   assign pop_ok  = pop && (occ != '0);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         occ <= occ + CW'(push_ok) - CW'(pop_ok);
      end
   end

   a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CW'(DEPTH) && push && !pop) |=> $stable(occ));
   a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0 && pop && !push) |=> (occ == '0));
endmodule

// File: rtl/pcm_fifo_status.sv
module pcm_fifo_status #(
   parameter int DEPTH = 2048,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] occ,
   input  logic [3:0]    level_code,
   input  logic          clr_we,
   input  logic [1:0]    clr_bits,
   input  logic [1:0]    irq_mask,
   input  logic          irq_en,
   output logic [1:0]    status,
   output logic          irq
);
   import pcm_fifo_pkg::*;

   logic [CW-1:0] thr;
   logic [1:0]    cond;

   assign thr            = CW'(DEPTH) >> level_code;
   assign cond[ST_UNDER] = (occ == '0);
   assign cond[ST_LEVEL] = (occ < thr);
   assign irq            = irq_en && ((status & irq_mask) != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status <= 2'b00;
      else if (clr_we) status <= status & ~clr_bits;
      else             status <= status | cond;
   end

   a_r5_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0 && !clr_we) |=> status[0]);
   a_r6_level_set: assert property (@(posedge clk) disable iff (!rst_n)
      (occ < (CW'(DEPTH) >> level_code) && !clr_we) |=> status[1]);
   a_r7_clear_under: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[0]) |=> !status[0]);
   a_r7_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[1]) |=> !status[1]);
endmodule

// File: rtl/pcm_fifo_regs.sv
module pcm_fifo_regs #(
   parameter int          DEPTH   = 2048,
   parameter int          ADDR_W  = 5,
   parameter logic [31:0] VERSION = 32'h0001_0200,
   localparam int         WORD_W  = ADDR_W - 2,
   localparam int         CW      = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic              fifo_pop,
   output logic [31:0]       fifo_data,
   output logic              fifo_empty,
   output logic              cfg_tx_en,
   output logic              cfg_irq_en,
   output logic              cfg_left_just,
   output logic [7:0]        cfg_clk_ratio,
   output logic [5:0]        cfg_sample_bits,
   output logic [3:0]        cfg_level_code,
   output logic [3:0]        cfg_chan_sel,
   output logic              irq
);
   import pcm_fifo_pkg::*;

   if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 16");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0x1C");
   end
   if (VERSION == 32'h0) begin : g_bad_version
      $error("VERSION must be nonzero");
   end

   logic [WORD_W-1:0] word;
   logic              aligned, wr_ok, rd_ok;
   logic [31:0]       cfg_q;
   logic [1:0]        mask_q, status;
   logic [CW-1:0]     occ;
   logic              push, clr_we;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr_ok   = bus_wr && aligned;
   assign rd_ok   = bus_rd && aligned;
   assign push    = wr_ok && (word == WORD_W'(W_DATA0));
   assign clr_we  = wr_ok && (word == WORD_W'(W_STATUS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '0;
      end else if (wr_ok) begin
         if (word == WORD_W'(W_CONFIG)) cfg_q  <= bus_wdata & CFG_KEEP;
         if (word == WORD_W'(W_MASK))   mask_q <= bus_wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (rd_ok) begin
         if (word == WORD_W'(W_VERSION))     bus_rdata <= VERSION;
         else if (word == WORD_W'(W_CONFIG)) bus_rdata <= cfg_q;
         else if (word == WORD_W'(W_MASK))   bus_rdata <= {30'b0, mask_q};
         else if (word == WORD_W'(W_STATUS)) bus_rdata <= {30'b0, status};
         else                                bus_rdata <= '0;
      end
   end

   assign cfg_tx_en       = cfg_q[0];
   assign cfg_irq_en      = cfg_q[1];
   assign cfg_left_just   = cfg_q[2];
   assign cfg_clk_ratio   = cfg_q[15:8];
   assign cfg_sample_bits = cfg_q[21:16];
   assign cfg_level_code  = cfg_q[27:24];
   assign cfg_chan_sel    = cfg_q[31:28];
   assign fifo_empty      = (occ == '0);

   pcm_fifo_store #(.DEPTH(DEPTH), .DW(32)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (bus_wdata),
      .pop       (fifo_pop),
      .head      (fifo_data),
      .occ       (occ)
   );

   pcm_fifo_status #(.DEPTH(DEPTH)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .occ        (occ),
      .level_code (cfg_level_code),
      .clr_we     (clr_we),
      .clr_bits   (bus_wdata[1:0]),
      .irq_mask   (mask_q),
      .irq_en     (cfg_irq_en),
      .status     (status),
      .irq        (irq)
   );

   a_r1_version_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == '0) |=> (bus_rdata == VERSION));
   a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cfg_irq_en);
   a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_q != 2'b00));
endmodule

// File: tb/pcm_fifo_regs_bench.sv
module pcm_fifo_regs_bench;
   localparam int          DEPTH = 2048;
   localparam logic [31:0] VER   = 32'h0001_0200;
   localparam logic [31:0] KEEP  = 32'hFF3F_FF07;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, fifo_pop = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, fifo_data;
   logic        fifo_empty, cfg_tx_en, cfg_irq_en, cfg_left_just, irq;
   logic [7:0]  cfg_clk_ratio;
   logic [5:0]  cfg_sample_bits;
   logic [3:0]  cfg_level_code, cfg_chan_sel;

   always #5 clk = ~clk;

   pcm_fifo_regs #(.DEPTH(DEPTH), .ADDR_W(5), .VERSION(VER)) u_pcm_fifo_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .fifo_pop(fifo_pop), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
      .cfg_tx_en(cfg_tx_en), .cfg_irq_en(cfg_irq_en), .cfg_left_just(cfg_left_just),
      .cfg_clk_ratio(cfg_clk_ratio), .cfg_sample_bits(cfg_sample_bits),
      .cfg_level_code(cfg_level_code), .cfg_chan_sel(cfg_chan_sel), .irq(irq)
   );

   // reference model
   logic [31:0] q[$];
   logic [31:0] m_cfg, m_rdata;
   logic [1:0]  m_st, m_mask;
   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "rdata", bus_rdata, m_rdata);
      chk(tag, "empty", {31'b0, fifo_empty}, {31'b0, q.size() == 0});
      if (q.size() > 0) chk(tag, "head", fifo_data, q[0]);
      chk(tag, "irq", {31'b0, irq}, {31'b0, m_cfg[1] && ((m_st & m_mask) != 2'b00)});
      chk(tag, "cfg_out", {cfg_chan_sel, cfg_level_code, 2'b0, cfg_sample_bits,
                           cfg_clk_ratio, 5'b0, cfg_left_just, cfg_irq_en, cfg_tx_en}, m_cfg);
   endtask

   task automatic step(string tag, bit wr, logic [4:0] a, logic [31:0] d, bit rd, bit pop);
      int          cnt;
      bit          al, push_ok, pop_ok;
      logic [1:0]  cond, n_st, n_mask;
      logic [31:0] n_cfg, n_rd;
      bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd; fifo_pop = pop;
      cnt  = q.size();
      al   = (a[1:0] == 2'b00);
      cond = {cnt < (DEPTH >> m_cfg[27:24]), cnt == 0};
      n_st = (wr && al && a == 5'h0C) ? (m_st & ~d[1:0]) : (m_st | cond);
      n_cfg  = (wr && al && a == 5'h04) ? (d & KEEP) : m_cfg;
      n_mask = (wr && al && a == 5'h08) ? d[1:0] : m_mask;
      n_rd = m_rdata;
      if (rd && al) begin
         case (a)
            5'h00:   n_rd = VER;
            5'h04:   n_rd = m_cfg;
            5'h08:   n_rd = {30'b0, m_mask};
            5'h0C:   n_rd = {30'b0, m_st};
            default: n_rd = '0;
         endcase
      end
      push_ok = wr && al && a == 5'h10 && cnt < DEPTH;
      pop_ok  = pop && cnt > 0;
      @(posedge clk);
      @(negedge clk);
      if (pop_ok)  void'(q.pop_front());
      if (push_ok) q.push_back(d);
      m_st = n_st; m_cfg = n_cfg; m_mask = n_mask; m_rdata = n_rd;
      bus_wr = 0; bus_rd = 0; fifo_pop = 0;
      compare(tag);
   endtask

   task automatic do_reset(string tag);
      @(negedge clk);
      rst_n = 0;
      bus_wr = 0; bus_rd = 0; fifo_pop = 0;
      q.delete();
      m_cfg = '0; m_rdata = '0; m_st = '0; m_mask = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      compare(tag);
   endtask

   initial begin
      do_reset("R9");
      step("R1", 0, 5'h00, 0, 1, 0);
      step("R1", 1, 5'h00, 32'hFFFF_FFFF, 0, 0);
      step("R1", 0, 5'h00, 0, 1, 0);
      step("R5", 0, 5'h0C, 0, 1, 0);
      step("R2", 1, 5'h04, 32'hFFFF_FFFF, 0, 0);
      step("R2", 0, 5'h04, 0, 1, 0);
      step("R2", 1, 5'h04, 32'h1414_5603, 0, 0);
      step("R2", 0, 5'h04, 0, 1, 0);
      step("R1", 1, 5'h05, 32'h0, 0, 0);       // misaligned write ignored
      step("R1", 0, 5'h06, 0, 1, 0);           // misaligned read ignored
      step("R8", 1, 5'h08, 32'h1, 0, 0);
      step("R10", 0, 5'h10, 0, 1, 0);
      step("R10", 0, 5'h1C, 0, 1, 0);
      step("R3", 1, 5'h14, 32'hDEAD_0001, 0, 0);
      step("R3", 1, 5'h18, 32'hDEAD_0002, 0, 0);
      step("R3", 1, 5'h1C, 32'hDEAD_0003, 0, 0);
      for (int i = 0; i < 5; i++) step("R3", 1, 5'h10, 32'hA000_0000 + i, 0, 0);
      step("R7", 1, 5'h0C, 32'h3, 0, 0);
      step("R7", 0, 5'h0C, 0, 1, 0);
      step("R7", 0, 5'h0C, 0, 1, 0);
      step("R8", 1, 5'h08, 32'h3, 0, 0);
      // level code 4: threshold DEPTH/16 = 128
      for (int i = 5; i < 127; i++) step("R6", 1, 5'h10, 32'hA000_0000 + i, 0, 0);
      step("R6", 1, 5'h0C, 32'h3, 0, 0);
      step("R6", 0, 5'h0C, 0, 1, 0);
      step("R6", 1, 5'h10, 32'hA000_007F, 0, 0);
      step("R6", 1, 5'h0C, 32'h3, 0, 0);
      step("R6", 0, 5'h0C, 0, 1, 0);
      step("R6", 0, 5'h0C, 0, 1, 0);
      for (int i = 0; i < 3; i++) step("R3", 0, 5'h00, 0, 0, 1);
      step("R6", 0, 5'h0C, 0, 1, 0);
      // level code 0: threshold DEPTH
      step("R6", 1, 5'h04, 32'h0000_0003, 0, 0);
      for (int i = 0; i < DEPTH; i++) step("R4", 1, 5'h10, 32'hB000_0000 + i, 0, 0);
      step("R4", 1, 5'h10, 32'hEEEE_0001, 0, 0);
      step("R4", 1, 5'h10, 32'hEEEE_0002, 0, 0);
      step("R6", 1, 5'h0C, 32'h3, 0, 0);
      step("R6", 0, 5'h0C, 0, 1, 0);
      step("R4", 1, 5'h10, 32'hEEEE_0003, 0, 1);
      while (q.size() > 0) step("R4", 0, 5'h00, 0, 0, 1);
      step("R11", 0, 5'h00, 0, 0, 1);
      step("R11", 0, 5'h00, 0, 0, 1);
      step("R11", 1, 5'h10, 32'hC000_0001, 0, 1);
      step("R5", 0, 5'h0C, 0, 1, 0);
      for (int i = 0; i < 4; i++) step("R9", 1, 5'h10, 32'hD000_0000 + i, 0, 0);
      do_reset("R9");
      step("R9", 0, 5'h08, 0, 1, 0);
      step("R9", 0, 5'h04, 0, 1, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule